// File: doc/BRIEF.md
# Idle Gap Timer for a Single-Wire Shared Bus

This block gates the start of a transmission on a single-wire, multi-drop bus. It measures how long the bus has been idle, in units of half a nominal data-bit period. It raises a permission flag once the required idle gap has passed and a transmit request is pending. Any bus activity while the timer is armed throws away the idle time gathered so far. The transmitter samples the permission flag and reports back when it actually starts to drive the line.

The required gap comes from a small code. A nonzero code n asks for n minus one half bit periods of idle bus. A code of zero selects a built-in default that depends on what happened last on the bus:
- 5 bit periods for a new initiator.
- 7 bit periods when retrying after a failed attempt.
- 3 bit periods when the same initiator follows its own successful frame.

A start-option input chooses what arms the timer. When it is low, a new software request arms it. When it is high, the end of any transmitted or received message arms it.

Top module: `idle_gap_timer`

## Requirements
- R1: After reset, permit_o and busy_o are low, and the default-mode history is "new initiator".
- R2: With gap_code_i = n (1..7), permit_o first rises after the clock edge that counts the (2n-1)th half_tick_i pulse after the arming event.
- R3: With gap_code_i = 0 and history "new initiator", the gap is 10 half ticks. The history becomes "new initiator" on rx_done_i.
- R4: With gap_code_i = 0 and history "retry", the gap is 14 half ticks. The history becomes "retry" on tx_fail_i.
- R5: With gap_code_i = 0 and history "same initiator", the gap is 6 half ticks. The history becomes "same initiator" on tx_done_i.
- R6: With auto_start_i = 0, only a rising edge of tx_req_i arms the timer. End pulses have no effect. While tx_req_i is low, the timer is disarmed and both outputs are low from the next cycle on.
- R7: With auto_start_i = 1, any of tx_done_i, tx_fail_i or rx_done_i re-arms the timer from zero. A rising edge of tx_req_i does not restart it. permit_o follows tx_req_i once the gap has elapsed.
- R8: bus_active_i high in a cycle while the timer is armed clears the idle count. The full gap must then pass again.
- R9: tx_begin_i disarms the timer, so both outputs are low in the next cycle. permit_o also falls in the same cycle that tx_req_i falls.
- R10: busy_o is high exactly while the timer is armed and the gap has not yet elapsed.
- R11: Once the gap has elapsed, the count holds, and permit_o stays high for as long as tx_req_i is held, with no new activity or arming. A half_tick_i in the cycle of an arming event is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | One-cycle pulse every half nominal bit period |
| gap_code_i | input | CODE_W | Idle gap code, 0 = default mode |
| auto_start_i | input | 1 | 0: arm on a new request; 1: arm on message end |
| tx_req_i | input | 1 | Software transmit request, held as a level |
| tx_begin_i | input | 1 | Pulse: the transmitter has started driving the bus |
| tx_done_i | input | 1 | Pulse: own transmission ended successfully |
| tx_fail_i | input | 1 | Pulse: own transmission ended in failure |
| rx_done_i | input | 1 | Pulse: a received message ended |
| bus_active_i | input | 1 | Bus activity seen this cycle |
| permit_o | output | 1 | Transmission may start |
| busy_o | output | 1 | Timer armed and still counting |

## Verification
The bench measures, for each code and each default history, the number of half ticks delivered before permit_o rises. A design with an off-by-one in the half-bit offset, or one that uses the wrong history, produces a count one or more ticks away from the expected value. It places bus activity mid-count and a tick in the arming cycle. A design that only pauses on activity, or that counts the arming tick, grants the bus early. It also checks that end pulses are ignored in request-armed mode and that a request edge is ignored in event-armed mode: swapping the two arming sources leaves busy_o wrong. A long random phase compares both outputs against a behavioural model on every clock.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;
  typedef enum logic [1:0] {
    HIST_NEW   = 2'd0,
    HIST_SAME  = 2'd1,
    HIST_RETRY = 2'd2
  } hist_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/igt_start_ctl.sv
module igt_start_ctl
  import idle_gap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  auto_start_i,
  input  logic  tx_req_i,
  input  logic  tx_done_i,
  input  logic  tx_fail_i,
  input  logic  rx_done_i,
  output logic  arm_o,
  output hist_e hist_o
);
  logic  req_q;
  logic  msg_end;
  hist_e hist_q;

  assign msg_end = tx_done_i | tx_fail_i | rx_done_i;
  assign arm_o   = auto_start_i ? msg_end : (tx_req_i & ~req_q);
  assign hist_o  = hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hist_q <= HIST_NEW;
    end else begin
      req_q <= tx_req_i;
      if (tx_fail_i)      hist_q <= HIST_RETRY;
      else if (tx_done_i) hist_q <= HIST_SAME;
      else if (rx_done_i) hist_q <= HIST_NEW;
    end
  end
endmodule

// File: rtl/igt_target.sv
module igt_target
  import idle_gap_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int CNT_W      = 4,
  parameter int NEW_BITS   = 5,
  parameter int RETRY_BITS = 7,
  parameter int SAME_BITS  = 3
) (
  input  logic [CODE_W-1:0] code_i,
  input  hist_e             hist_i,
  output logic [CNT_W-1:0]  halves_o
);
  // nonzero code n -> n-0.5 bit periods = 2n-1 half periods
  always_comb begin
    if (code_i == '0) begin
      unique case (hist_i)
        HIST_SAME:  halves_o = CNT_W'(2 * SAME_BITS);
        HIST_RETRY: halves_o = CNT_W'(2 * RETRY_BITS);
        default:    halves_o = CNT_W'(2 * NEW_BITS);
      endcase
    end else begin
      halves_o = CNT_W'({code_i, 1'b0}) - CNT_W'(1);
    end
  end
endmodule

// File: rtl/igt_half_cnt.sv
module igt_half_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             arm_i,
  input  logic             tick_i,
  input  logic             activity_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             armed_o,
  output logic             done_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o  = cnt_q >= limit_i;
  assign armed_o = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (stop_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (activity_i)            cnt_q <= '0;
      else if (tick_i && !done_o) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer
  import idle_gap_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int NEW_BITS   = 5,
  parameter int RETRY_BITS = 7,
  parameter int SAME_BITS  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_tick_i,
  input  logic [CODE_W-1:0] gap_code_i,
  input  logic              auto_start_i,
  input  logic              tx_req_i,
  input  logic              tx_begin_i,
  input  logic              tx_done_i,
  input  logic              tx_fail_i,
  input  logic              rx_done_i,
  input  logic              bus_active_i,
  output logic              permit_o,
  output logic              busy_o
);
  localparam int MaxCodeHalves = 2 * ((1 << CODE_W) - 1) - 1;
  localparam int MaxDefHalves  = 2 * max2(NEW_BITS, max2(RETRY_BITS, SAME_BITS));
  localparam int CntW          = $clog2(max2(MaxCodeHalves, MaxDefHalves) + 1);

  logic            arm;
  logic            stop;
  logic            armed;
  logic            done;
  hist_e           hist;
  logic [CntW-1:0] limit;

  // request withdrawn in request-armed mode disarms
  assign stop = tx_begin_i | (~auto_start_i & ~tx_req_i);

  igt_start_ctl u_start (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .auto_start_i (auto_start_i),
    .tx_req_i     (tx_req_i),
    .tx_done_i    (tx_done_i),
    .tx_fail_i    (tx_fail_i),
    .rx_done_i    (rx_done_i),
    .arm_o        (arm),
    .hist_o       (hist)
  );

  igt_target #(
    .CODE_W     (CODE_W),
    .CNT_W      (CntW),
    .NEW_BITS   (NEW_BITS),
    .RETRY_BITS (RETRY_BITS),
    .SAME_BITS  (SAME_BITS)
  ) u_target (
    .code_i   (gap_code_i),
    .hist_i   (hist),
    .halves_o (limit)
  );

  igt_half_cnt #(.CNT_W(CntW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (stop),
    .arm_i      (arm),
    .tick_i     (half_tick_i),
    .activity_i (bus_active_i),
    .limit_i    (limit),
    .armed_o    (armed),
    .done_o     (done)
  );

  assign permit_o = armed & done & tx_req_i;
  assign busy_o   = armed & ~done;
endmodule

// File: rtl/idle_gap_timer_chk.sv
module idle_gap_timer_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              half_tick_i,
  input logic [CODE_W-1:0] gap_code_i,
  input logic              auto_start_i,
  input logic              tx_req_i,
  input logic              tx_begin_i,
  input logic              tx_done_i,
  input logic              tx_fail_i,
  input logic              rx_done_i,
  input logic              bus_active_i,
  input logic              permit_o,
  input logic              busy_o
);
  logic msg_end;
  assign msg_end = tx_done_i | tx_fail_i | rx_done_i;

  // R9
  begin_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_begin_i |=> !permit_o && !busy_o);

  // R6
  manual_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_start_i && !tx_req_i |=> !permit_o && !busy_o);

  // R7
  auto_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_start_i && msg_end && !tx_begin_i |=> busy_o);

  // R8
  activity_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_active_i && (busy_o || permit_o) && !tx_begin_i && (auto_start_i || tx_req_i)
    |=> busy_o);

  // R11
  permit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_o && !bus_active_i && !tx_begin_i && !msg_end
    |=> permit_o || !tx_req_i || (gap_code_i != $past(gap_code_i)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !permit_o && !tx_req_i && !msg_end && !auto_start_i |=> !busy_o);
endmodule

bind idle_gap_timer idle_gap_timer_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/idle_gap_timer_tb.sv
module idle_gap_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       half_tick_i = 1'b0;
  logic [2:0] gap_code_i = 3'd0;
  logic       auto_start_i = 1'b0;
  logic       tx_req_i = 1'b0;
  logic       tx_begin_i = 1'b0;
  logic       tx_done_i = 1'b0;
  logic       tx_fail_i = 1'b0;
  logic       rx_done_i = 1'b0;
  logic       bus_active_i = 1'b0;
  logic       permit_o;
  logic       busy_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    ended = 0;
  string tag = "R1";

  // reference state
  int m_arm = 0;
  int m_cnt = 0;
  int m_hist = 0;  // 0 new, 1 same, 2 retry
  int m_reqp = 0;

  idle_gap_timer u_dut (.*);

  always #4 clk_i = ~clk_i;

  function automatic int gap_halves(input int code, input int hist);
    if (code != 0) return 2 * code - 1;
    if (hist == 1) return 6;
    if (hist == 2) return 14;
    return 10;
  endfunction

  task automatic check(input string r, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit tk, input bit bb, input bit ts,
                            input bit td, input bit tf, input bit rd);
    int tgt;
    bit st;
    tgt = gap_halves(int'(gap_code_i), m_hist);
    st  = auto_start_i ? (td | tf | rd) : (tx_req_i && m_reqp == 0);
    if (ts) begin
      m_arm = 0; m_cnt = 0;
    end else if (st) begin
      m_arm = 1; m_cnt = 0;
    end else if (!auto_start_i && !tx_req_i) begin
      m_arm = 0; m_cnt = 0;
    end else if (m_arm == 1) begin
      if (bb) m_cnt = 0;
      else if (tk && m_cnt < tgt) m_cnt++;
    end
    if (tf) m_hist = 2;
    else if (td) m_hist = 1;
    else if (rd) m_hist = 0;
    m_reqp = int'(tx_req_i);
  endtask

  task automatic cyc(input bit tk, input bit bb = 0, input bit ts = 0,
                     input bit td = 0, input bit tf = 0, input bit rd = 0);
    int tgt;
    half_tick_i = tk; bus_active_i = bb; tx_begin_i = ts;
    tx_done_i = td; tx_fail_i = tf; rx_done_i = rd;
    @(posedge clk_i);
    model_step(tk, bb, ts, td, tf, rd);
    @(negedge clk_i);
    tgt = gap_halves(int'(gap_code_i), m_hist);
    check(tag, int'(busy_o), int'(m_arm == 1 && m_cnt < tgt), "busy_o vs model");
    check(tag, int'(permit_o), int'(m_arm == 1 && m_cnt >= tgt && tx_req_i), "permit_o vs model");
  endtask

  // counts half ticks delivered until permit_o is first seen
  task automatic measure(input int exp_h, input string r);
    int  ticks = 0;
    bit  seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      bit tk = (i % 2 == 0);
      cyc(tk);
      if (tk) ticks++;
      if (permit_o) seen = 1;
    end
    check(r, seen ? ticks : -1, exp_h, "half ticks until permit");
  endtask

  task automatic rearm_manual();
    tx_req_i = 1'b0; cyc(0);
    tx_req_i = 1'b1; cyc(0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    tag = "R1";
    check("R1", int'(permit_o), 0, "permit after reset");
    check("R1", int'(busy_o), 0, "busy after reset");

    // R3: new-initiator default right after reset
    tag = "R3";
    gap_code_i = 3'd0;
    tx_req_i = 1'b1; cyc(0);
    measure(10, "R3");
    // R9: start of transmission drops permission
    tag = "R9";
    cyc(0, 0, 1);
    check("R9", int'(permit_o), 0, "permit after tx_begin");
    tx_req_i = 1'b0; cyc(0);

    // R6: end pulse does not arm in request-armed mode
    tag = "R6";
    cyc(0, 0, 0, 0, 1);
    cyc(0);
    check("R6", int'(busy_o), 0, "busy after end pulse, manual mode");
    // R4: retry default
    tag = "R4";
    tx_req_i = 1'b1; cyc(0);
    measure(14, "R4");
    tag = "R9";
    tx_req_i = 1'b0;
    #1 check("R9", int'(permit_o), 0, "permit same cycle as withdrawal");
    cyc(0);
    check("R9", int'(busy_o), 0, "busy after withdrawal");

    // R5: same-initiator default
    tag = "R5";
    cyc(0, 0, 0, 1);
    tx_req_i = 1'b1; cyc(0);
    measure(6, "R5");
    cyc(0, 0, 1);

    // R3: history back to new after a received message
    tag = "R3";
    tx_req_i = 1'b0;
    cyc(0, 0, 0, 0, 0, 1);
    tx_req_i = 1'b1; cyc(0);
    measure(10, "R3");

    // R2: every programmed code
    tag = "R2";
    for (int c = 1; c < 8; c++) begin
      gap_code_i = 3'(c);
      rearm_manual();
      measure(2 * c - 1, "R2");
    end

    // R8: activity mid-count restarts the gap
    tag = "R8";
    gap_code_i = 3'd4;
    rearm_manual();
    for (int i = 0; i < 8; i++) cyc(i % 2 == 0);
    cyc(0, 1);
    check("R8", int'(busy_o), 1, "busy after activity");
    measure(7, "R8");

    // R7: message-end arming
    tag = "R7";
    gap_code_i = 3'd3;
    auto_start_i = 1'b1;
    cyc(0, 0, 1);
    tx_req_i = 1'b0; cyc(0);
    tx_req_i = 1'b1; cyc(0);
    check("R7", int'(busy_o), 0, "request edge does not arm in auto mode");
    cyc(0, 0, 0, 1);
    check("R7", int'(busy_o), 1, "end pulse arms in auto mode");
    measure(5, "R7");

    // R11: saturation keeps permission
    tag = "R11";
    for (int i = 0; i < 20; i++) cyc(1);
    check("R11", int'(permit_o), 1, "permit held after many ticks");
    tag = "R7";
    tx_req_i = 1'b0; cyc(1);
    check("R7", int'(permit_o), 0, "permit low without request");
    tx_req_i = 1'b1; cyc(0);
    check("R7", int'(permit_o), 1, "permit follows request once elapsed");

    // R11: tick in the arming cycle is not counted
    tag = "R11";
    cyc(1, 0, 0, 0, 0, 1);
    measure(5, "R11");

    // random phase against the model
    tag = "R10";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) auto_start_i = ~auto_start_i;
      if ($urandom_range(0, 299) == 0) gap_code_i = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 39) == 0) tx_req_i = ~tx_req_i;
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 59) == 0,
          $urandom_range(0, 149) == 0, $urandom_range(0, 99) == 0,
          $urandom_range(0, 149) == 0, $urandom_range(0, 99) == 0);
    end
    cyc(0);

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule